// File: doc/BRIEF.md
# Debug Acknowledge Pulse Generator

This block runs on the target side of a single-wire, open-drain debug link. It tells the host that a debug command has finished. All timing is counted in ticks of the serial bit clock. A one-cycle `tick_i` strobe marks each tick, and the block runs on the fast system clock. The command receiver raises `cmd_end_i` on the tick that closes the last command bit, and tags the command as a read, a write or a control command. The bus interface later raises `exec_done_i` once the command has been carried out.

The block holds the pin released until two things are true: enough ticks have passed since the command end, and execution has finished. It then drives the pin low for a fixed number of ticks. Next it drives the pin actively high for a short speed-up phase, so the line does not have to wait on the pull-up. Finally it releases the pin.

When the pulse is over, the block reports the next phase. A read moves to data return. A write or a control command goes back to accepting a new command. If the device enters stop mode before execution completes, the pending command is dropped and no pulse is sent. There is no upper bound on how long the block waits for execution.

Top module: `ack_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `pin_oe_o`, `pin_do_o`, `busy_o`, `rd_data_phase_o` and `ack_done_o` are all 0.
- R2: The low phase (`pin_oe_o`=1, `pin_do_o`=0) spans exactly LOW_TICKS ticks (default 16).
- R3: The low phase is followed at once by a speed-up phase (`pin_oe_o`=1, `pin_do_o`=1) lasting SPD_TICKS ticks (default 1). After that `pin_oe_o` returns to 0. `pin_do_o` is never 1 while `pin_oe_o` is 0.
- R4: The low phase never starts before GAP_TICKS ticks (default 32) have passed after the cycle holding the accepted `cmd_end_i`. The tick in that cycle is not counted. If `exec_done_i` came earlier, `pin_oe_o` rises in the cycle after the GAP_TICKS-th tick.
- R5: The wait has no upper bound. When `exec_done_i` comes after the gap has elapsed, the pulse starts on the first tick at or after the strobe cycle.
- R6: If `stop_i` is high while a command waits and execution has not completed, the command is dropped. `busy_o` falls on the next cycle, and no pulse and no `ack_done_o` follow. This also applies when `stop_i` and `exec_done_i` arrive in the same cycle.
- R7: `stop_i` has no effect once `exec_done_i` has been seen for the pending command, and none while the pulse is being driven.
- R8: `ack_done_o` pulses for one cycle as the pin is released. At that point `rd_data_phase_o` becomes 1 for class 2'b00 (read) and 0 for 2'b01 (write), 2'b10 or 2'b11 (control). It holds that value until the next accepted command end clears it.
- R9: A `cmd_end_i` that arrives while `busy_o` is high is ignored and does not restart the gap.
- R10: `busy_o` goes high in the cycle after an accepted `cmd_end_i` (one that arrives while `busy_o` is low). It stays high until the pin is released or the command is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per serial clock tick |
| cmd_end_i | input | 1 | Command-end strobe (closing tick of last command bit) |
| cmd_class_i | input | 2 | Command class: 00 read, 01 write, 10/11 control |
| exec_done_i | input | 1 | Execution-complete strobe from the bus interface |
| stop_i | input | 1 | Stop-mode indication |
| pin_oe_o | output | 1 | Debug pin output enable (0 = high impedance) |
| pin_do_o | output | 1 | Debug pin drive value |
| busy_o | output | 1 | A command is pending or its pulse is in progress |
| rd_data_phase_o | output | 1 | Last completed command was a read: data return may begin |
| ack_done_o | output | 1 | One-cycle strobe at pin release |

## Verification
The bench builds the block with its default parameters: a 16-tick low phase, a 32-tick minimum gap and a one-tick speed-up. A tick comes every third system clock, so every phase boundary falls between tick strobes and off-tick clock cycles are exercised. These values bring in the following cases:
- execution finishing both well before and long after the gap;
- stop arriving before completion, in the same cycle as completion, after completion and during the low phase;
- a stray command end while busy.

Each completed command's measured gap, low width and speed-up width are compared against the exact figures.

// File: rtl/ack_pkg.sv
package ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_SPD  = 2'd3
  } ack_st_e;

  localparam logic [1:0] CLS_READ  = 2'b00;
  localparam logic [1:0] CLS_WRITE = 2'b01;
  localparam logic [1:0] CLS_CTRL  = 2'b10;
endpackage

// File: rtl/ack_gap_timer.sv
module ack_gap_timer #(
  parameter int GAP_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic gap_hit_o
);
  localparam int CW = $clog2(GAP_TICKS + 1);

  logic [CW-1:0] cnt_q;

  // saturating tick count since the accepted command end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i && cnt_q != CW'(GAP_TICKS)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // true on a tick that reaches or lies beyond the minimum gap
  assign gap_hit_o = run_i && tick_i && (cnt_q >= CW'(GAP_TICKS - 1));
endmodule

// File: rtl/ack_pulse_shaper.sv
module ack_pulse_shaper #(
  parameter int LOW_TICKS = 16,
  parameter int SPD_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic drive_low_i,
  input  logic drive_spd_i,
  output logic low_last_o,
  output logic spd_last_o,
  output logic pin_oe_o,
  output logic pin_do_o
);
  localparam int MAXT = (LOW_TICKS > SPD_TICKS) ? LOW_TICKS : SPD_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q;
  logic          active;

  assign active     = drive_low_i | drive_spd_i;
  assign low_last_o = drive_low_i && tick_i && (cnt_q == CW'(LOW_TICKS - 1));

  generate
    if (SPD_TICKS > 0) begin : g_spd
      assign spd_last_o = drive_spd_i && tick_i && (cnt_q == CW'(SPD_TICKS - 1));
    end else begin : g_nospd
      assign spd_last_o = 1'b0;
    end
  endgenerate

  // per-phase tick counter, restarts at each phase boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active || low_last_o || spd_last_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pin_oe_o = active;
  assign pin_do_o = drive_spd_i;
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import ack_pkg::*;
#(
  parameter int SPD_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_end_i,
  input  logic [1:0] cmd_class_i,
  input  logic       exec_done_i,
  input  logic       stop_i,
  input  logic       gap_hit_i,
  input  logic       low_last_i,
  input  logic       spd_last_i,
  output logic       gap_clear_o,
  output logic       gap_run_o,
  output logic       drive_low_o,
  output logic       drive_spd_o,
  output logic       busy_o,
  output logic       rd_data_phase_o,
  output logic       ack_done_o
);
  localparam bit HAS_SPD = (SPD_TICKS > 0);

  ack_st_e    st_q, st_d;
  logic       done_q;
  logic [1:0] cls_q;
  logic       rd_q;
  logic       ack_q;
  logic       accept, cancel, done_now, start, release_p;

  assign accept    = (st_q == ST_IDLE) && cmd_end_i;
  // stop only drops a command whose execution has not been seen
  assign cancel    = (st_q == ST_WAIT) && stop_i && !done_q;
  assign done_now  = done_q | exec_done_i;
  assign start     = (st_q == ST_WAIT) && !cancel && gap_hit_i && done_now;
  assign release_p = ((st_q == ST_SPD) && spd_last_i) ||
                     (!HAS_SPD && (st_q == ST_LOW) && low_last_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (cmd_end_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (cancel)     st_d = ST_IDLE;
        else if (start) st_d = ST_LOW;
      end
      ST_LOW:  if (low_last_i) st_d = HAS_SPD ? ST_SPD : ST_IDLE;
      ST_SPD:  if (spd_last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      cls_q  <= CLS_WRITE;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= release_p;
      if (accept) begin
        cls_q  <= cmd_class_i;
        done_q <= 1'b0;
      end else if (st_q == ST_WAIT) begin
        done_q <= cancel ? 1'b0 : done_now;
      end
      if (release_p)   rd_q <= (cls_q == CLS_READ);
      else if (accept) rd_q <= 1'b0;
    end
  end

  assign gap_clear_o     = accept;
  assign gap_run_o       = (st_q == ST_WAIT);
  assign drive_low_o     = (st_q == ST_LOW);
  assign drive_spd_o     = (st_q == ST_SPD);
  assign busy_o          = (st_q != ST_IDLE);
  assign rd_data_phase_o = rd_q;
  assign ack_done_o      = ack_q;
endmodule

// File: rtl/ack_pulse_gen.sv
module ack_pulse_gen #(
  parameter int LOW_TICKS = 16,
  parameter int GAP_TICKS = 32,
  parameter int SPD_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_end_i,
  input  logic [1:0] cmd_class_i,
  input  logic       exec_done_i,
  input  logic       stop_i,
  output logic       pin_oe_o,
  output logic       pin_do_o,
  output logic       busy_o,
  output logic       rd_data_phase_o,
  output logic       ack_done_o
);
  logic gap_clear, gap_run, gap_hit;
  logic drive_low, drive_spd, low_last, spd_last;

  ack_gap_timer #(
    .GAP_TICKS(GAP_TICKS)
  ) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (gap_clear),
    .run_i    (gap_run),
    .tick_i   (tick_i),
    .gap_hit_o(gap_hit)
  );

  ack_seq #(
    .SPD_TICKS(SPD_TICKS)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_end_i      (cmd_end_i),
    .cmd_class_i    (cmd_class_i),
    .exec_done_i    (exec_done_i),
    .stop_i         (stop_i),
    .gap_hit_i      (gap_hit),
    .low_last_i     (low_last),
    .spd_last_i     (spd_last),
    .gap_clear_o    (gap_clear),
    .gap_run_o      (gap_run),
    .drive_low_o    (drive_low),
    .drive_spd_o    (drive_spd),
    .busy_o         (busy_o),
    .rd_data_phase_o(rd_data_phase_o),
    .ack_done_o     (ack_done_o)
  );

  ack_pulse_shaper #(
    .LOW_TICKS(LOW_TICKS),
    .SPD_TICKS(SPD_TICKS)
  ) u_shaper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .drive_low_i(drive_low),
    .drive_spd_i(drive_spd),
    .low_last_o (low_last),
    .spd_last_o (spd_last),
    .pin_oe_o   (pin_oe_o),
    .pin_do_o   (pin_do_o)
  );
endmodule

// File: rtl/ack_pulse_gen_chk.sv
module ack_pulse_gen_chk #(
  parameter int LOW_TICKS = 16,
  parameter int GAP_TICKS = 32,
  parameter int SPD_TICKS = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic cmd_end_i,
  input logic exec_done_i,
  input logic stop_i,
  input logic pin_oe_o,
  input logic pin_do_o,
  input logic busy_o,
  input logic ack_done_o
);
  int   low_cnt;
  int   gap_cnt;
  logic dseen;
  logic low_ph;

  assign low_ph = pin_oe_o && !pin_do_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= 0;
      gap_cnt <= 0;
      dseen   <= 1'b0;
    end else begin
      if (!low_ph)     low_cnt <= 0;
      else if (tick_i) low_cnt <= low_cnt + 1;
      if (cmd_end_i && !busy_o) gap_cnt <= 0;
      else if (busy_o && !pin_oe_o && tick_i && gap_cnt < GAP_TICKS) gap_cnt <= gap_cnt + 1;
      if (cmd_end_i && !busy_o) dseen <= 1'b0;
      else if (busy_o && exec_done_i && !stop_i) dseen <= 1'b1;
    end
  end

  // R3
  tri_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_do_o);

  // R2
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_ph |-> low_cnt < LOW_TICKS);

  // R2
  low_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_ph && tick_i && low_cnt == LOW_TICKS - 1) |=> !low_ph);

  // R3
  spd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!low_ph && $past(low_ph)) |-> (pin_oe_o == (SPD_TICKS != 0)));

  // R4
  min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> gap_cnt == GAP_TICKS);

  // R6
  stop_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pin_oe_o && stop_i && !dseen) |=> (!busy_o && !pin_oe_o));

  // R8
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_o |-> (!busy_o && !pin_oe_o && $past(pin_oe_o)));

  // R10
  busy_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_end_i && !busy_o) |=> busy_o);
endmodule

bind ack_pulse_gen ack_pulse_gen_chk #(
  .LOW_TICKS(LOW_TICKS),
  .GAP_TICKS(GAP_TICKS),
  .SPD_TICKS(SPD_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cmd_end_i  (cmd_end_i),
  .exec_done_i(exec_done_i),
  .stop_i     (stop_i),
  .pin_oe_o   (pin_oe_o),
  .pin_do_o   (pin_do_o),
  .busy_o     (busy_o),
  .ack_done_o (ack_done_o)
);

// File: tb/ack_pulse_gen_bench.sv
`timescale 1ns/1ps
module ack_pulse_gen_bench;
  localparam int LOW = 16;
  localparam int GAP = 32;
  localparam int SPD = 1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       cmd_end_i = 1'b0;
  logic [1:0] cmd_class_i = 2'b01;
  logic       exec_done_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       pin_oe_o, pin_do_o, busy_o, rd_data_phase_o, ack_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int tdiv = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ack_pulse_gen #(.LOW_TICKS(LOW), .GAP_TICKS(GAP), .SPD_TICKS(SPD)) u_ack_pulse_gen (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cmd_end_i(cmd_end_i),
    .cmd_class_i(cmd_class_i), .exec_done_i(exec_done_i), .stop_i(stop_i),
    .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .busy_o(busy_o),
    .rd_data_phase_o(rd_data_phase_o), .ack_done_o(ack_done_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // tick every third clock, updated just after the edge
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick_i = (tdiv == 0);
  end

  // reference model state (integers)
  int ms = 0, gap = 0, dl = 0, lc = 0, sc = 0, cls = 1, rdph = 0, mack = 0;
  // measurements
  int pulses = 0, acks = 0, last_rd = 0, prev_oe = 0;
  int gcnt = 0, garm = 0, dcnt = 0, darm = 0, lowc = 0, spdc = 0;
  int meas_gap = 0, meas_dgap = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      ms = 0; gap = 0; dl = 0; lc = 0; sc = 0; cls = 1; rdph = 0; mack = 0;
      prev_oe = 0;
    end else begin
      // R2 R3 pin drive, R10 busy, R8 phase and strobe
      check("R2 pin_oe", int'(pin_oe_o), int'(ms == 2 || ms == 3));
      check("R3 pin_do", int'(pin_do_o), int'(ms == 3));
      check("R10 busy", int'(busy_o), int'(ms != 0));
      check("R8 rd_phase", int'(rd_data_phase_o), rdph);
      check("R8 ack_done", int'(ack_done_o), mack);

      if (pin_oe_o && !prev_oe) begin
        pulses++; meas_gap = gcnt; meas_dgap = dcnt;
        garm = 0; darm = 0; lowc = 0; spdc = 0;
      end
      if (pin_oe_o && !pin_do_o && tick_i) lowc++;
      if (pin_oe_o && pin_do_o && tick_i) spdc++;
      if (ack_done_o) begin acks++; last_rd = rd_data_phase_o; end
      if (cmd_end_i && !busy_o) begin gcnt = 0; garm = 1; darm = 0; end
      else if (garm && !pin_oe_o && tick_i) gcnt++;
      if (exec_done_i && busy_o && !darm && !pin_oe_o) begin darm = 1; dcnt = int'(tick_i); end
      else if (darm && !pin_oe_o && tick_i) dcnt++;
      prev_oe = int'(pin_oe_o);

      // model step for the coming edge
      mack = 0;
      case (ms)
        0: if (cmd_end_i) begin ms = 1; gap = 0; dl = 0; cls = int'(cmd_class_i); rdph = 0; end
        1: begin
          if (stop_i && dl == 0) begin ms = 0; dl = 0; end
          else begin
            if (exec_done_i) dl = 1;
            if (tick_i) begin
              if (gap < GAP) gap++;
              if (gap >= GAP && dl == 1) begin ms = 2; lc = 0; end
            end
          end
        end
        2: if (tick_i) begin lc++; if (lc == LOW) begin ms = 3; sc = 0; end end
        3: if (tick_i) begin
          sc++;
          if (sc == SPD) begin ms = 0; mack = 1; rdph = int'(cls == 0); end
        end
        default: ms = 0;
      endcase
    end
  end

  task automatic issue(input logic [1:0] c);
    @(posedge clk); #1 cmd_end_i = 1'b1; cmd_class_i = c;
    @(posedge clk); #1 cmd_end_i = 1'b0;
  endtask

  task automatic strobe_done();
    @(posedge clk); #1 exec_done_i = 1'b1;
    @(posedge clk); #1 exec_done_i = 1'b0;
  endtask

  task automatic strobe_stop();
    @(posedge clk); #1 stop_i = 1'b1;
    @(posedge clk); #1 stop_i = 1'b0;
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick_i) @(posedge clk);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy_o && guard < 5000) begin @(negedge clk); guard++; end
    check("R10 busy release", int'(busy_o), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pulse(input string tag, input int p0, input int a0, input int rd);
    check({tag, " R2 low ticks"}, lowc, LOW);
    check({tag, " R3 speed-up ticks"}, spdc, SPD);
    check({tag, " pulse count"}, pulses, p0 + 1);
    check({tag, " R8 ack count"}, acks, a0 + 1);
    check({tag, " R8 rd phase"}, last_rd, rd);
    check({tag, " R3 released"}, int'(pin_oe_o), 0);
  endtask

  initial begin
    int p0, a0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 oe in reset", int'(pin_oe_o), 0);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 rd in reset", int'(rd_data_phase_o), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", int'(pin_oe_o), 0);
    check("R1 do after reset", int'(pin_do_o), 0);
    check("R1 ack after reset", int'(ack_done_o), 0);

    // read, execution done early: exact minimum gap (R4)
    p0 = pulses; a0 = acks;
    issue(2'b00); tick_wait(5); strobe_done(); wait_idle();
    check("read R4 gap", meas_gap, GAP);
    check_pulse("read", p0, a0, 1);

    // write, execution very late: first tick after strobe (R5)
    p0 = pulses; a0 = acks;
    issue(2'b01); tick_wait(50); strobe_done(); wait_idle();
    check("write R5 late start", meas_dgap, 1);
    check_pulse("write", p0, a0, 0);

    // control 10 and 11 return to command phase (R8)
    p0 = pulses; a0 = acks;
    issue(2'b10); tick_wait(10); strobe_done(); wait_idle();
    check("ctrl R4 gap", meas_gap, GAP);
    check_pulse("ctrl10", p0, a0, 0);
    p0 = pulses; a0 = acks;
    issue(2'b11); tick_wait(120); strobe_done(); wait_idle();
    check("ctrl11 R5 late start", meas_dgap, 1);
    check_pulse("ctrl11", p0, a0, 0);

    // read then cancel by stop: rd phase cleared by acceptance (R6, R8)
    p0 = pulses; a0 = acks;
    issue(2'b00); tick_wait(3); strobe_done(); wait_idle();
    check("pre-cancel R8 rd", int'(rd_data_phase_o), 1);
    p0 = pulses; a0 = acks;
    issue(2'b00); tick_wait(10); strobe_stop(); wait_idle();
    tick_wait(40);
    check("R6 no pulse", pulses, p0);
    check("R6 no ack", acks, a0);
    check("R6 R8 rd cleared", int'(rd_data_phase_o), 0);

    // stop and done in the same cycle: cancelled (R6)
    p0 = pulses; a0 = acks;
    issue(2'b01); tick_wait(8);
    @(posedge clk); #1 stop_i = 1'b1; exec_done_i = 1'b1;
    @(posedge clk); #1 stop_i = 1'b0; exec_done_i = 1'b0;
    wait_idle(); tick_wait(40);
    check("R6 same-cycle no pulse", pulses, p0);
    check("R6 same-cycle no ack", acks, a0);

    // stop after execution done: pulse still issued (R7)
    p0 = pulses; a0 = acks;
    issue(2'b00); tick_wait(3); strobe_done(); tick_wait(7); strobe_stop(); wait_idle();
    check("R7 stop after done gap", meas_gap, GAP);
    check_pulse("R7 late stop", p0, a0, 1);

    // stop during the low phase: no effect (R7)
    p0 = pulses; a0 = acks;
    issue(2'b01); tick_wait(2); strobe_done();
    @(negedge clk); while (!pin_oe_o) @(negedge clk);
    tick_wait(4); strobe_stop(); wait_idle();
    check_pulse("R7 stop in low", p0, a0, 0);

    // second command end while busy is ignored (R9)
    p0 = pulses; a0 = acks;
    issue(2'b10); tick_wait(4); strobe_done(); tick_wait(16); issue(2'b00); wait_idle();
    check("R9 gap not restarted", meas_gap, GAP);
    check_pulse("R9", p0, a0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule